// File: doc/BRIEF.md
# Brown-out Reset Sequencer

This block is the digital control that sits around an external supply comparator. The comparator drives a single bit, `cmp_low`, which is high while the supply is under the detection threshold. Software arms the block in two steps. First it turns on the detector. A hardware settle counter then runs for a programmable number of cycles. Only after that count has finished will the block accept the reset-enable bit. A power-on option bit can skip this sequence, in which case the block leaves hardware reset already armed.

Once the block is armed, the comparator is synchronised into the low-speed oscillator domain. A low supply has to be seen on two consecutive synchronised samples before anything happens. When it is, the block drives the active-low internal reset `rst_n_o`. After the supply recovers, the block holds that reset for a fixed number of oscillator cycles, 32 by default. If the supply drops again during that hold, the count starts over. A start-type flag reads 0 (cold) after every monitor reset, and any software write to the status address sets it to 1 (warm).

The whole block runs on `clk`, which is the low-speed oscillator clock. Hardware reset `rst` is synchronous and active high. `rst_n_o` reflects only the monitor reset and reads 1 while `rst` is applied.

Top module: `bor_seq_ctrl`

## Requirements
- R1: While `rst` is applied and after it is released, `rst_n_o`=1, `warm_o`=0 and `settle_busy_o`=0. When `cfg_mon_off`=0, `det_en_o`=1 and `mon_en_o`=1. When `cfg_mon_off`=1, both are 0.
- R2: Address 0 is the control register: bit 0 is the detector enable and bit 1 is the monitor-reset enable. Address 1, bits [7:0], holds the settle length N (reset value 8). A write to address 0 that changes the detector enable from 0 to 1 makes `settle_busy_o` high for exactly N cycles. N=0 gives no busy cycle. Writing 1 when the detector enable is already 1 does not restart the count.
- R3: A write to bit 1 of the control register is ignored while `settle_busy_o` is high. It is also ignored while the detector enable read before the write is 0, and this includes a write that sets both bits at once.
- R4: Reset is asserted only when both enables are 1 and `cmp_low` has been high on two consecutive clock edges. If `cmp_low` rises before edge 1, `rst_n_o` is still 1 after edge 3 and is 0 after edge 4. With either enable at 0, `cmp_low` has no effect on `rst_n_o`.
- R5: A `cmp_low` pulse that spans only one clock edge never asserts reset.
- R6: If `cmp_low` falls before edge 1 of the recovery, `rst_n_o` is still 0 after edge 33 and is 1 after edge 34. That is 32 counted cycles after synchroniser latency.
- R7: If `cmp_low` is high again on two consecutive edges during the hold, `rst_n_o` stays 0 and the hold count restarts from the new recovery.
- R8: `warm_o` goes to 0 on the same edge on which a monitor reset is asserted. Any write to address 2 sets `warm_o` to 1 unless a monitor reset is active on that edge, in which case the reset wins.
- R9: A write to address 3 changes none of the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed oscillator clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| cfg_mon_off | input | 1 | Power-on option: 1 means monitor reset starts disabled |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| cmp_low | input | 1 | Comparator output, high when supply is under threshold (asynchronous) |
| rst_n_o | output | 1 | Active-low internal reset |
| det_en_o | output | 1 | Detector enable state |
| mon_en_o | output | 1 | Monitor-reset enable state |
| settle_busy_o | output | 1 | Settle counter running |
| warm_o | output | 1 | Start-type flag, 0 = cold, 1 = warm |

## Verification
Four rules are checked by assertions on every cycle. The monitor-reset enable never rises while settling or while the detector is off. A reset edge is always preceded by both enables and by two high comparator samples. The flag reads cold on every reset edge. Every release follows at least the full hold count of low cycles. The exact edge counts of assertion and release, the restart after a second dip, the busy length for each settle value and the filtering of one-edge pulses of different widths can only be shown by the bench's timed scenarios and sweeps.

// File: rtl/bor_pkg.sv
package bor_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_SETTLE = 2'd1,
    REG_STAT   = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;

  localparam int CTRL_DET_BIT = 0;
  localparam int CTRL_MON_BIT = 1;
endpackage

// File: rtl/bor_sync.sv
// Synchroniser chain followed by a history flop; qual_o is high when the
// last two synchronised samples were both high.
module bor_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic qual_o
);
  logic [STAGES-1:0] chain;
  logic              hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      hist  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      hist  <= chain[STAGES-1];
    end
  end

  assign qual_o = chain[STAGES-1] & hist;
endmodule

// File: rtl/bor_settle.sv
// Down-counter for the detector settle wait.
module bor_settle #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] len,
  output logic         busy_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (start)      cnt <= len;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);
endmodule

// File: rtl/bor_hold.sv
// Holds the active-low reset while tripped and for HOLD_CYC cycles after.
module bor_hold #(
  parameter int HOLD_CYC = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic trip,
  output logic rst_n_o
);
  localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_n_o <= 1'b1;
      cnt     <= '0;
    end else if (trip) begin
      rst_n_o <= 1'b0;
      cnt     <= '0;
    end else if (!rst_n_o) begin
      if (cnt == LAST) begin
        rst_n_o <= 1'b1;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bor_seq_ctrl.sv
module bor_seq_ctrl
  import bor_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SETTLE_W    = 8,
  parameter int SETTLE_DEF  = 8,
  parameter int HOLD_CYC    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_mon_off,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmp_low,
  output logic              rst_n_o,
  output logic              det_en_o,
  output logic              mon_en_o,
  output logic              settle_busy_o,
  output logic              warm_o
);
  localparam logic [SETTLE_W-1:0] LEN_RST = SETTLE_W'(SETTLE_DEF);

  logic                wr_ctrl, wr_len, wr_stat;
  logic                settle_start;
  logic                low_qual;
  logic                trip;
  logic [SETTLE_W-1:0] settle_len;

  assign wr_ctrl = wr_en && (wr_addr == REG_CTRL);
  assign wr_len  = wr_en && (wr_addr == REG_SETTLE);
  assign wr_stat = wr_en && (wr_addr == REG_STAT);

  // Only a 0 -> 1 change of the detector enable starts the settle wait.
  assign settle_start = wr_ctrl && wr_data[CTRL_DET_BIT] && !det_en_o;

  assign trip = det_en_o && mon_en_o && low_qual;

  always_ff @(posedge clk) begin
    if (rst) begin
      det_en_o   <= ~cfg_mon_off;
      mon_en_o   <= ~cfg_mon_off;
      settle_len <= LEN_RST;
      warm_o     <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        det_en_o <= wr_data[CTRL_DET_BIT];
        if (!settle_busy_o && det_en_o)
          mon_en_o <= wr_data[CTRL_MON_BIT];
      end
      if (wr_len)
        settle_len <= wr_data[SETTLE_W-1:0];
      if (trip)
        warm_o <= 1'b0;
      else if (wr_stat)
        warm_o <= 1'b1;
    end
  end

  bor_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (cmp_low),
    .qual_o   (low_qual)
  );

  bor_settle #(.W(SETTLE_W)) u_settle (
    .clk    (clk),
    .rst    (rst),
    .start  (settle_start),
    .len    (settle_len),
    .busy_o (settle_busy_o)
  );

  bor_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .trip    (trip),
    .rst_n_o (rst_n_o)
  );
endmodule

// File: rtl/bor_seq_chk.sv
module bor_seq_chk #(
  parameter int HOLD_CYC = 32
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic       cmp_low,
  input logic       rst_n_o,
  input logic       det_en_o,
  input logic       mon_en_o,
  input logic       settle_busy_o,
  input logic       warm_o
);
  localparam int RUN_W = $clog2(HOLD_CYC + 2) + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

  logic [RUN_W-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || rst_n_o)          low_run <= '0;
    else if (low_run != RUN_MAX) low_run <= low_run + 1'b1;
  end

  // R3: enable-bit write during settling leaves the enable unchanged
  a_r3_gate_busy: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd0 && settle_busy_o) |=> $stable(mon_en_o));

  // R3: enable only rises after settling with the detector on
  a_r3_rise_gated: assert property (@(posedge clk) disable iff (rst)
    $rose(mon_en_o) |-> $past(det_en_o && !settle_busy_o));

  // R4: a reset edge needs both enables
  a_r4_armed: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_n_o) |-> $past(det_en_o && mon_en_o));

  // R4: a reset edge needs two consecutive high comparator samples
  a_r4_two_samples: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_n_o) |-> ($past(cmp_low, 3) && $past(cmp_low, 4)));

  // R8: flag reads cold on each reset edge
  a_r8_cold_on_trip: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_n_o) |-> !warm_o);

  // R6: release only after at least the full hold count
  a_r6_hold_min: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> (low_run >= RUN_W'(HOLD_CYC)));
endmodule

bind bor_seq_ctrl bor_seq_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .cmp_low       (cmp_low),
  .rst_n_o       (rst_n_o),
  .det_en_o      (det_en_o),
  .mon_en_o      (mon_en_o),
  .settle_busy_o (settle_busy_o),
  .warm_o        (warm_o)
);

// File: tb/sim_bor_seq_ctrl.sv
module sim_bor_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_mon_off = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       cmp_low = 1'b0;
  logic       rst_n_o, det_en_o, mon_en_o, settle_busy_o, warm_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bor_seq_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_mon_off(cfg_mon_off),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmp_low(cmp_low), .rst_n_o(rst_n_o), .det_en_o(det_en_o),
    .mon_en_o(mon_en_o), .settle_busy_o(settle_busy_o), .warm_o(warm_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic hw_reset(input logic cfg);
    cfg_mon_off = cfg;
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    step(1);
  endtask

  task automatic wait_release();
    for (int i = 0; i < 200 && !rst_n_o; i++) step(1);
    step(4);
  endtask

  initial begin
    step(1);
    // R1: option set, monitor starts disabled
    hw_reset(1'b1);
    check("R1 det cfg1", det_en_o, 0);
    check("R1 mon cfg1", mon_en_o, 0);
    check("R1 busy", settle_busy_o, 0);
    check("R1 warm", warm_o, 0);
    check("R1 rst_n", rst_n_o, 1);

    // R3: setting both bits at once only enables the detector
    wr(2'd0, 8'h03);
    check("R3 det set", det_en_o, 1);
    check("R3 mon same write", mon_en_o, 0);
    check("R2 busy after start", settle_busy_o, 1);
    wr(2'd0, 8'h03);
    check("R3 mon while busy", mon_en_o, 0);
    for (int i = 0; i < 300 && settle_busy_o; i++) step(1);
    wr(2'd0, 8'h03);
    check("R3 mon after settle", mon_en_o, 1);

    // R2: sweep the settle length
    for (int n = 0; n <= 7; n++) begin
      int cnt;
      wr(2'd0, 8'h00);
      wr(2'd1, 8'(n));
      wr(2'd0, 8'h01);
      cnt = 0;
      while (settle_busy_o && cnt < 300) begin
        cnt++;
        step(1);
      end
      check("R2 busy length", cnt, n);
    end
    wr(2'd1, 8'd6);
    wr(2'd0, 8'h01);
    check("R2 redundant set no restart", settle_busy_o, 0);

    // R1: option clear, monitor armed out of reset
    hw_reset(1'b0);
    check("R1 det cfg0", det_en_o, 1);
    check("R1 mon cfg0", mon_en_o, 1);
    check("R1 warm cfg0", warm_o, 0);

    // R8: status write sets warm
    wr(2'd2, 8'h00);
    check("R8 warm set", warm_o, 1);

    // R9: spare address ignored
    wr(2'd3, 8'hFF);
    check("R9 det", det_en_o, 1);
    check("R9 mon", mon_en_o, 1);
    check("R9 warm", warm_o, 1);
    check("R9 busy", settle_busy_o, 0);
    check("R9 rst_n", rst_n_o, 1);

    // R5 / R4: sweep the pulse width
    for (int w = 1; w <= 4; w++) begin
      bit tripped;
      wr(2'd2, 8'h00);
      cmp_low = 1'b1;
      step(w);
      cmp_low = 1'b0;
      tripped = 1'b0;
      for (int i = 0; i < 8; i++) begin
        if (!rst_n_o) tripped = 1'b1;
        step(1);
      end
      check(w == 1 ? "R5 one-edge pulse" : "R4 pulse trips", int'(tripped), int'(w >= 2));
      check("R8 warm after pulse", warm_o, int'(w < 2));
      wait_release();
    end

    // R4: exact assertion edge
    wr(2'd2, 8'h00);
    cmp_low = 1'b1;
    step(3);
    check("R4 not yet after 3 edges", rst_n_o, 1);
    check("R8 warm before trip", warm_o, 1);
    step(1);
    check("R4 asserted after 4 edges", rst_n_o, 0);
    check("R8 cold on trip", warm_o, 0);
    wr(2'd2, 8'h00);
    check("R8 trip beats status write", warm_o, 0);

    // R6: exact release edge
    step(3);
    cmp_low = 1'b0;
    step(33);
    check("R6 held after 33", rst_n_o, 0);
    step(1);
    check("R6 released after 34", rst_n_o, 1);

    // R7: second dip during hold restarts the count
    cmp_low = 1'b1;
    step(6);
    cmp_low = 1'b0;
    step(10);
    cmp_low = 1'b1;
    step(2);
    cmp_low = 1'b0;
    step(33);
    check("R7 held after restart", rst_n_o, 0);
    step(1);
    check("R7 released after restart", rst_n_o, 1);
    step(4);

    // R4: disarmed monitor ignores the comparator
    wr(2'd0, 8'h01);
    check("R4 mon cleared", mon_en_o, 0);
    wr(2'd2, 8'h00);
    cmp_low = 1'b1;
    step(10);
    check("R4 disarmed no reset", rst_n_o, 1);
    check("R4 disarmed warm kept", warm_o, 1);
    cmp_low = 1'b0;
    step(4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule